// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by running two direction predictors side by side and choosing between them per branch. The first keeps a short outcome history for each branch slot, picked by the low bits of the branch address. It mixes that history with the address to reach a table of 2-bit saturating counters. The second keeps a single history of the most recent outcomes across all branches and mixes it with the address to reach a second counter table. A third table of 2-bit chooser counters, indexed by the address, learns which of the two has been right more often for that branch and steers the output.

A fetch stage presents a branch address on the lookup port and reads the predicted direction, together with a flag telling which side supplied it, in the same cycle. When the branch resolves, the resolve port carries its address and actual direction. At the next clock edge both counter tables are trained, the chooser is trained, and both histories take in the outcome. Resolves are expected in program order, directly after the matching lookup. The update therefore rebuilds its indices from the histories as they stand at resolve, which equal the ones seen at lookup. Target addresses and wrong-path recovery are handled elsewhere.

Top module: `tourn_pred`

## Requirements
- R1: After reset every history is zero, every direction counter is weakly not-taken (2'b01) and every chooser is weakly local (2'b01). Any lookup then returns predTaken=0 and useGlobal=0.
- R2: The local prediction is the MSB of the local counter at index lHist[pc[LSEL_W-1:0]] XOR pc[LHIST_W-1:0].
- R3: The global prediction is the MSB of the global counter at index gHist XOR pc[GHIST_W-1:0].
- R4: The chooser at index pc[CHOOSE_W-1:0] selects the source. MSB=1 gives the global prediction and MSB=0 the local one. useGlobal shows the MSB.
- R5: On resolve, a chooser counter steps up (toward global) when only the global side was right, and steps down when only the local side was right. It is unchanged when both sides agreed.
- R6: On every resolve, both direction counters addressed by the branch are trained. Each steps up on taken and down on not-taken, saturating at 2'b11 and 2'b00.
- R7: On resolve, the branch's own local history and the global history each shift left, with the outcome entering at bit 0. No other local history changes.
- R8: Resolve indices are formed from the histories present before that resolve's shift. A lookup in the same cycle as a resolve sees the state from before that update.
- R9: While resolveValid is low, no counter or history changes, whatever resolvePc and resolveTaken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupPc | input | PC_W | Low address bits of the branch being predicted |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| useGlobal | output | 1 | 1 when the global side supplied predTaken |
| resolveValid | input | 1 | A branch outcome is presented this cycle |
| resolvePc | input | PC_W | Low address bits of the resolving branch |
| resolveTaken | input | 1 | Actual direction of the resolving branch |

## Verification
A lookup and a resolve can fall in the same cycle. The lookup must then return the state from before the resolve's training and shift, while the resolve's own indices come from the unshifted histories. Every step of the vector table drives both ports with the same branch in the same cycle. The prediction is sampled before the edge and compared with hand-derived state. The next step only matches if the update used the pre-shift indices. Two alternating branches with opposite outcomes make the local and global sides disagree, so the chooser moves while the history is still shifting.

// File: rtl/tourn_pred_pkg.sv
package tourn_pred_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LO = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic train;       // train both direction tables
    logic dirTaken;    // resolved direction
    logic chooseUp;    // move chooser toward global
    logic chooseDown;  // move chooser toward local
    logic shift;       // shift outcome into histories
  } strobe_t;

  function automatic ctr2_t satStep(ctr2_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/tourn_pred_ctr_table.sv
module tourn_pred_ctr_table
  import tourn_pred_pkg::*;
#(
  parameter int    IDX_W = 3,
  parameter ctr2_t INIT  = CTR_WEAK_LO
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output ctr2_t            rdVal,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrUp,
  output ctr2_t            wrOld
);
  localparam int N = 1 << IDX_W;

  ctr2_t ctr [N];

  assign rdVal = ctr[rdIdx];
  assign wrOld = ctr[wrIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) ctr[i] <= INIT;
    end else if (wrEn) begin
      ctr[wrIdx] <= satStep(ctr[wrIdx], wrUp);
    end
  end
endmodule

// File: rtl/tourn_pred_ctrl.sv
module tourn_pred_ctrl
  import tourn_pred_pkg::*;
(
  input  logic    resolveValid,
  input  logic    resolveTaken,
  input  logic    localRes,
  input  logic    globalRes,
  output strobe_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.train    = resolveValid;
    strobes.shift    = resolveValid;
    strobes.dirTaken = resolveTaken;
    if (resolveValid && (localRes != globalRes)) begin
      strobes.chooseUp   = (globalRes == resolveTaken);
      strobes.chooseDown = (localRes == resolveTaken);
    end
  end
endmodule

// File: rtl/tourn_pred_dp.sv
module tourn_pred_dp
  import tourn_pred_pkg::*;
#(
  parameter int PC_W     = 3,
  parameter int LSEL_W   = 2,
  parameter int LHIST_W  = 3,
  parameter int GHIST_W  = 3,
  parameter int CHOOSE_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  input  logic [PC_W-1:0] resolvePc,
  input  strobe_t         strobes,
  output logic            predTaken,
  output logic            useGlobal,
  output logic            localRes,
  output logic            globalRes
);
  localparam int LSEL_N = 1 << LSEL_W;

  logic [LHIST_W-1:0] lHist [LSEL_N];
  logic [GHIST_W-1:0] gHist;

  logic [LSEL_W-1:0]   lkSel, rsSel;
  logic [LHIST_W-1:0]  lkLIdx, rsLIdx;
  logic [GHIST_W-1:0]  lkGIdx, rsGIdx;
  logic [CHOOSE_W-1:0] lkCIdx, rsCIdx;
  ctr2_t lkLocal, lkGlobal, lkChoose;
  ctr2_t rsLocal, rsGlobal, unusedChooseOld;

  // index formation, lookup and resolve sides
  assign lkSel  = lookupPc[LSEL_W-1:0];
  assign rsSel  = resolvePc[LSEL_W-1:0];
  assign lkLIdx = lHist[lkSel] ^ lookupPc[LHIST_W-1:0];
  assign rsLIdx = lHist[rsSel] ^ resolvePc[LHIST_W-1:0];
  assign lkGIdx = gHist ^ lookupPc[GHIST_W-1:0];
  assign rsGIdx = gHist ^ resolvePc[GHIST_W-1:0];
  assign lkCIdx = lookupPc[CHOOSE_W-1:0];
  assign rsCIdx = resolvePc[CHOOSE_W-1:0];

  // per-slot local histories
  for (genvar h = 0; h < LSEL_N; h++) begin : g_lhist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lHist[h] <= '0;
      else if (strobes.shift && (rsSel == LSEL_W'(h)))
        lHist[h] <= {lHist[h][LHIST_W-2:0], strobes.dirTaken};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gHist <= '0;
    else if (strobes.shift) gHist <= {gHist[GHIST_W-2:0], strobes.dirTaken};
  end

  tourn_pred_ctr_table #(.IDX_W(LHIST_W), .INIT(CTR_WEAK_LO)) u_local (
    .clk(clk), .rstN(rstN), .rdIdx(lkLIdx), .rdVal(lkLocal),
    .wrEn(strobes.train), .wrIdx(rsLIdx), .wrUp(strobes.dirTaken), .wrOld(rsLocal)
  );

  tourn_pred_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_LO)) u_global (
    .clk(clk), .rstN(rstN), .rdIdx(lkGIdx), .rdVal(lkGlobal),
    .wrEn(strobes.train), .wrIdx(rsGIdx), .wrUp(strobes.dirTaken), .wrOld(rsGlobal)
  );

  tourn_pred_ctr_table #(.IDX_W(CHOOSE_W), .INIT(CTR_WEAK_LO)) u_choose (
    .clk(clk), .rstN(rstN), .rdIdx(lkCIdx), .rdVal(lkChoose),
    .wrEn(strobes.chooseUp | strobes.chooseDown), .wrIdx(rsCIdx),
    .wrUp(strobes.chooseUp), .wrOld(unusedChooseOld)
  );

  assign useGlobal = lkChoose[1];
  assign predTaken = useGlobal ? lkGlobal[1] : lkLocal[1];
  assign localRes  = rsLocal[1];
  assign globalRes = rsGlobal[1];
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
  import tourn_pred_pkg::*;
#(
  parameter int PC_W     = 3,
  parameter int LSEL_W   = 2,
  parameter int LHIST_W  = 3,
  parameter int GHIST_W  = 3,
  parameter int CHOOSE_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  output logic            useGlobal,
  input  logic            resolveValid,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken
);
  strobe_t strobes;
  logic    localRes;
  logic    globalRes;

  tourn_pred_ctrl u_ctrl (
    .resolveValid(resolveValid), .resolveTaken(resolveTaken),
    .localRes(localRes), .globalRes(globalRes), .strobes(strobes)
  );

  tourn_pred_dp #(
    .PC_W(PC_W), .LSEL_W(LSEL_W), .LHIST_W(LHIST_W),
    .GHIST_W(GHIST_W), .CHOOSE_W(CHOOSE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .resolvePc(resolvePc),
    .strobes(strobes), .predTaken(predTaken), .useGlobal(useGlobal),
    .localRes(localRes), .globalRes(globalRes)
  );
endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk
  import tourn_pred_pkg::*;
#(
  parameter int PC_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] lookupPc,
  input logic            predTaken,
  input logic            useGlobal,
  input logic            resolveValid,
  input logic            resolveTaken,
  input strobe_t         strobes,
  input logic            localRes,
  input logic            globalRes
);
  AST_RESET_STATE: assert property (@(posedge clk) !rstN |=> (!predTaken && !useGlobal)); // R1

  AST_CHOOSE_ONEWAY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.chooseUp, strobes.chooseDown})); // R5

  AST_CHOOSE_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (localRes == globalRes) |-> (!strobes.chooseUp && !strobes.chooseDown)); // R5

  AST_CHOOSE_TOWARD: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && globalRes == resolveTaken && localRes != resolveTaken) |-> strobes.chooseUp); // R5

  AST_TRAIN_ON_RESOLVE: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid |-> (strobes.train && strobes.shift && strobes.dirTaken == resolveTaken)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(resolveValid) && $stable(lookupPc)) |-> ($stable(predTaken) && $stable(useGlobal))); // R9
endmodule

bind tourn_pred tourn_pred_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken),
  .useGlobal(useGlobal), .resolveValid(resolveValid), .resolveTaken(resolveTaken),
  .strobes(strobes), .localRes(localRes), .globalRes(globalRes)
);

// File: tb/tourn_pred_tb_top.sv
module tourn_pred_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {pc[2:0], taken, expPred, expUseGlobal}; branch A = pc 0, branch B = pc 1
  localparam logic [5:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b0, 1'b0, 1'b0},
    {3'd0, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b0, 1'b0, 1'b0},
    {3'd0, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b0, 1'b0, 1'b0},
    {3'd0, 1'b1, 1'b1, 1'b1},
    {3'd1, 1'b0, 1'b0, 1'b0},
    {3'd0, 1'b1, 1'b1, 1'b1},
    {3'd1, 1'b0, 1'b0, 1'b0},
    {3'd0, 1'b0, 1'b1, 1'b1},
    {3'd0, 1'b1, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] lookupPc = '0;
  logic [2:0] resolvePc = '0;
  logic       resolveValid = 1'b0;
  logic       resolveTaken = 1'b0;
  logic       predTaken;
  logic       useGlobal;

  int nTests = 0;
  int nFail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourn_pred dut_i (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken),
    .useGlobal(useGlobal), .resolveValid(resolveValid), .resolvePc(resolvePc),
    .resolveTaken(resolveTaken)
  );

  task automatic check(input logic act, input logic exp, input string what);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // drive at the falling edge, settle, then the caller samples before the rising edge
  task automatic drive(input logic [2:0] pc, input logic rv, input logic rt);
    @(negedge clk);
    lookupPc = pc; resolvePc = pc; resolveValid = rv; resolveTaken = rt;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; resolveValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    doReset();
    // R1: reset state
    drive(3'd5, 1'b0, 1'b0);
    check(predTaken, 1'b0, "R1 pred after reset");
    check(useGlobal, 1'b0, "R1 source after reset");

    // vector walk: lookup and resolve of the same branch in every cycle
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][5:3], 1'b1, VEC[v][2]);
      check(predTaken, VEC[v][1], $sformatf("vector %0d pred (R2 R3 R4 R6 R7 R8)", v));
      check(useGlobal, VEC[v][0], $sformatf("vector %0d source (R4 R5 R8)", v));
    end

    // R1: reset again after training
    doReset();
    drive(3'd0, 1'b0, 1'b0);
    check(predTaken, 1'b0, "R1 pred after second reset");
    check(useGlobal, 1'b0, "R1 source after second reset");

    // R9: resolve data with valid low is ignored
    for (int k = 0; k < 6; k++) drive(3'd0, 1'b0, 1'b1);
    drive(3'd0, 1'b0, 1'b1);
    check(predTaken, 1'b0, "R9 idle resolve ignored");

    // R6: six taken resolves of branch A, counter saturates high at index 7
    for (int k = 0; k < 6; k++) begin
      drive(3'd0, 1'b1, 1'b1);
      check(predTaken, (k >= 4) ? 1'b1 : 1'b0, $sformatf("R6 taken run step %0d", k));
    end
    drive(3'd0, 1'b0, 1'b0);
    check(predTaken, 1'b1, "R6 saturated high");
    check(useGlobal, 1'b0, "R5 agreement keeps chooser");

    resolveValid = 1'b0;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule